// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Watermark Interrupts

This block is an asynchronous serial transmitter and receiver with a 32-bit register port. Software puts bytes into an 8-entry transmit queue by writing one register. It takes bytes from an 8-entry receive queue by reading another. The serial bit period is set by a programmable divisor counted in input clock cycles. Transmit and receive each have an enable bit and a 3-bit watermark.

The interrupt output is a level signal. Each direction has a pending condition that depends only on its queue fill and its watermark. The receive condition holds while more bytes are waiting than the watermark. The transmit condition holds while fewer bytes are queued than the watermark. A pending bit drops by itself as soon as its condition stops holding, so there is no clear action.

The register port is single cycle. Read data is combinational from the register selector. A read strobe on the receive data register removes the head byte at the clock edge.

Top module: `serial_port_wm`

## Requirements
- R1: After reset, the divisor reads 4340 and the control and enable registers read 0. The pending register reads 0, txOut is high and irqOut is low.
- R2: Word index 0 is transmit data. A read returns bit 31 set while the transmit queue holds 8 bytes. A write queues bits 7:0 when the queue is not full, and a write to a full queue is discarded.
- R3: Word index 1 is receive data. A read returns the oldest byte in bits 7:0 with bit 31 clear, and removes that byte. When the queue is empty, a read returns bit 31 set and removes nothing.
- R4: Bit 0 of the transmit control register (index 2) enables the transmitter. While it is 0, no new frame starts and txOut stays high.
- R5: A transmitted frame is one low start bit, then 8 data bits sent least significant bit first, then one high stop bit, or two when bit 1 of transmit control is set. Each bit lasts the divisor value in clock cycles (index 6), and queued frames follow each other with no gap.
- R6: Bit 0 of the receive control register (index 3) enables the receiver. The receiver samples each bit at its middle, counted from the falling edge of the start bit. Frames that arrive while the receiver is disabled are discarded.
- R7: A received byte that completes while the receive queue holds 8 bytes is dropped, and the 8 bytes already queued are kept.
- R8: Pending bit 1 (register index 5) is 1 exactly while the receive queue count is greater than the receive watermark in bits 18:16 of receive control.
- R9: Pending bit 0 is 1 exactly while the transmit queue count is less than the transmit watermark in bits 18:16 of transmit control. A watermark of 0 never raises it.
- R10: The pending register is read-only, and a write to it changes nothing.
- R11: irqOut is 1 while any pending bit is set whose enable bit is set in the interrupt enable register (index 4), where bit 0 enables transmit and bit 1 enables receive.
- R12: The divisor register (index 6) reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 3 | Register word index |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe (removes a byte on index 1) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from regSel |
| txOut | output | 1 | Serial transmit line, high when idle |
| rxIn | input | 1 | Serial receive line |
| irqOut | output | 1 | Level interrupt |

## Verification
Two events can fall in the same clock cycle. One is the receiver completing a byte and pushing it into the receive queue. The other is a software read popping that same queue. The bench loops txOut back to rxIn and polls the receive data register on every cycle while eight frames arrive, so a poll lands on each push cycle. It judges the result by requiring every byte to come out exactly once and in order, with an empty indication once the stream ends.

// File: rtl/serial_port_pkg.sv
`timescale 1ns/1ps
package serial_port_pkg;
  typedef enum logic [2:0] {
    REG_TXD = 3'd0, REG_RXD = 3'd1, REG_TXC = 3'd2, REG_RXC = 3'd3,
    REG_IE  = 3'd4, REG_IP  = 3'd5, REG_DIV = 3'd6
  } regSelT;

  typedef struct packed {
    logic       txPush;
    logic       rxPop;
    logic [7:0] txByte;
  } stbT;

  typedef enum logic { TX_IDLE, TX_SEND } txStateT;
  typedef enum logic [1:0] { RX_IDLE, RX_START, RX_DATA, RX_STOP } rxStateT;
endpackage

// File: rtl/serial_fifo.sv
`timescale 1ns/1ps
module serial_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPop  = pop && !empty;
  assign doPush = push && (!full || doPop);
  assign dout   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R2 R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> (count == CNT_W'(DEPTH)));
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/serial_port_dp.sv
`timescale 1ns/1ps
module serial_port_dp
  import serial_port_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  stbT              stb,
  input  logic             txEn,
  input  logic             rxEn,
  input  logic             twoStop,
  input  logic [DIV_W-1:0] divisor,
  input  logic             rxIn,
  output logic             txOut,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic             txFull,
  output logic             rxEmpty,
  output logic [7:0]       rxHead
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] divEff;
  assign divEff = (divisor == '0) ? ONE : divisor;

  // transmit queue and engine
  logic       txEmpty, txStart, txTick, txDone;
  logic [7:0] txHead;
  txStateT    txState;
  logic [10:0] txShift;
  logic [3:0]  txBits;
  logic [DIV_W-1:0] txDiv;

  serial_fifo #(.DEPTH(DEPTH), .WIDTH(8)) txQ (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .pop(txStart), .din(stb.txByte),
    .dout(txHead), .count(txCount), .full(txFull), .empty(txEmpty));

  assign txTick  = (txDiv == '0);
  assign txDone  = (txState == TX_SEND) && txTick && (txBits == 4'd1);
  assign txStart = txEn && !txEmpty && ((txState == TX_IDLE) || txDone);
  assign txOut   = (txState == TX_SEND) ? txShift[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txShift <= '1;
      txBits  <= '0;
      txDiv   <= '0;
    end else if (txStart) begin
      txShift <= {2'b11, txHead, 1'b0};
      txBits  <= twoStop ? 4'd11 : 4'd10;
      txDiv   <= divEff - ONE;
      txState <= TX_SEND;
    end else if (txDone) begin
      txState <= TX_IDLE;
    end else if (txState == TX_SEND) begin
      if (txTick) begin
        txShift <= {1'b1, txShift[10:1]};
        txBits  <= txBits - 4'd1;
        txDiv   <= divEff - ONE;
      end else begin
        txDiv <= txDiv - ONE;
      end
    end
  end

  // receive engine and queue
  logic [1:0] rxSync;
  logic       rxS, rxTick, rxPush;
  rxStateT    rxState;
  logic [2:0] rxBits;
  logic [7:0] rxShift;
  logic [DIV_W-1:0] rxDiv;
  logic       rxFull;

  assign rxS    = rxSync[1];
  assign rxTick = (rxDiv == '0);
  assign rxPush = rxEn && (rxState == RX_STOP) && rxTick && rxS;

  serial_fifo #(.DEPTH(DEPTH), .WIDTH(8)) rxQ (
    .clk(clk), .rstN(rstN), .push(rxPush), .pop(stb.rxPop), .din(rxShift),
    .dout(rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSync  <= 2'b11;
      rxState <= RX_IDLE;
      rxBits  <= '0;
      rxShift <= '0;
      rxDiv   <= '0;
    end else begin
      rxSync <= {rxSync[0], rxIn};
      if (!rxEn) begin
        rxState <= RX_IDLE;
      end else begin
        case (rxState)
          RX_IDLE: if (!rxS) begin
            rxState <= RX_START;
            rxDiv   <= divEff >> 1;
          end
          RX_START: if (rxTick) begin
            rxState <= rxS ? RX_IDLE : RX_DATA;
            rxDiv   <= divEff - ONE;
            rxBits  <= '0;
          end else rxDiv <= rxDiv - ONE;
          RX_DATA: if (rxTick) begin
            rxShift <= {rxS, rxShift[7:1]};
            rxDiv   <= divEff - ONE;
            rxBits  <= rxBits + 3'd1;
            if (rxBits == 3'd7) rxState <= RX_STOP;
          end else rxDiv <= rxDiv - ONE;
          default: if (rxTick) rxState <= RX_IDLE;
                   else rxDiv <= rxDiv - ONE;
        endcase
      end
    end
  end

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txEn && txState == TX_IDLE) |=> (txState == TX_IDLE && txOut));
  // R6
  rx_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEn && rxState == RX_IDLE) |=> $stable(rxCount) || $past(stb.rxPop));
  // R7
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !stb.rxPop) |=> (rxCount == CNT_W'(DEPTH)));
endmodule

// File: rtl/serial_port_ctrl.sv
`timescale 1ns/1ps
module serial_port_ctrl
  import serial_port_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 4340,
  parameter int CNT_W     = 4,
  parameter int WM_W      = 3,
  parameter int WM_LSB    = 16,
  localparam int FLAG_BIT = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut,
  output stbT               stb,
  output logic              txEn,
  output logic              rxEn,
  output logic              twoStop,
  output logic [DIV_W-1:0]  divisor,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              txFull,
  input  logic              rxEmpty,
  input  logic [7:0]        rxHead
);
  logic [WM_W-1:0] txWm, rxWm;
  logic [1:0] ie, pend;
  regSelT sel;
  logic unusedWdata;

  assign sel = regSelT'(regSel);
  assign unusedWdata = ^regWdata;

  assign stb.txPush = regWr && (sel == REG_TXD);
  assign stb.txByte = regWdata[7:0];
  assign stb.rxPop  = regRd && (sel == REG_RXD) && !rxEmpty;

  assign pend[0] = int'(txCount) < int'(txWm);
  assign pend[1] = int'(rxCount) > int'(rxWm);
  assign irqOut  = |(pend & ie);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEn <= 1'b0; twoStop <= 1'b0; txWm <= '0;
      rxEn <= 1'b0; rxWm <= '0; ie <= '0;
      divisor <= DIV_W'(DIV_RESET);
    end else if (regWr) begin
      case (sel)
        REG_TXC: begin
          txEn    <= regWdata[0];
          twoStop <= regWdata[1];
          txWm    <= regWdata[WM_LSB +: WM_W];
        end
        REG_RXC: begin
          rxEn <= regWdata[0];
          rxWm <= regWdata[WM_LSB +: WM_W];
        end
        REG_IE:  ie      <= regWdata[1:0];
        REG_DIV: divisor <= regWdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    case (sel)
      REG_TXD: regRdata[FLAG_BIT] = txFull;
      REG_RXD: begin
        regRdata[FLAG_BIT] = rxEmpty;
        regRdata[7:0]      = rxEmpty ? 8'h00 : rxHead;
      end
      REG_TXC: begin
        regRdata[1:0] = {twoStop, txEn};
        regRdata[WM_LSB +: WM_W] = txWm;
      end
      REG_RXC: begin
        regRdata[0] = rxEn;
        regRdata[WM_LSB +: WM_W] = rxWm;
      end
      REG_IE:  regRdata[1:0] = ie;
      REG_IP:  regRdata[1:0] = pend;
      REG_DIV: regRdata[DIV_W-1:0] = divisor;
      default: ;
    endcase
  end

  // R8
  rx_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    pend[1] |-> !rxEmpty);
  // R9
  tx_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    pend[0] |-> (!txFull && txWm != '0));
  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (ie != 2'b00));
endmodule

// File: rtl/serial_port_wm.sv
`timescale 1ns/1ps
module serial_port_wm
  import serial_port_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int DATA_W    = 32,
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 4340,
  parameter int WM_W      = 3,
  parameter int WM_LSB    = 16,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              txOut,
  input  logic              rxIn,
  output logic              irqOut
);
  stbT stb;
  logic txEn, rxEn, twoStop, txFull, rxEmpty;
  logic [DIV_W-1:0] divisor;
  logic [CNT_W-1:0] txCount, rxCount;
  logic [7:0] rxHead;

  serial_port_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET),
                     .CNT_W(CNT_W), .WM_W(WM_W), .WM_LSB(WM_LSB)) ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut), .stb(stb),
    .txEn(txEn), .rxEn(rxEn), .twoStop(twoStop), .divisor(divisor),
    .txCount(txCount), .rxCount(rxCount), .txFull(txFull), .rxEmpty(rxEmpty),
    .rxHead(rxHead));

  serial_port_dp #(.DEPTH(DEPTH), .DIV_W(DIV_W)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txEn(txEn), .rxEn(rxEn),
    .twoStop(twoStop), .divisor(divisor), .rxIn(rxIn), .txOut(txOut),
    .txCount(txCount), .rxCount(rxCount), .txFull(txFull), .rxEmpty(rxEmpty),
    .rxHead(rxHead));
endmodule

// File: tb/serial_port_wm_test.sv
`timescale 1ns/1ps
module serial_port_wm_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regSel = 3'd0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic txOut, irqOut;
  logic loop = 1'b0, rxDrv = 1'b1;
  logic rxIn;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  assign rxIn = loop ? txOut : rxDrv;

  serial_port_wm uut (.clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regRd(regRd), .regWdata(regWdata), .regRdata(regRdata), .txOut(txOut),
    .rxIn(rxIn), .irqOut(irqOut));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      failures++;
      $display("FAIL watchdog: run did not finish (actual=%0d expected<150000)", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); regSel = s; regWdata = d; regWr = 1'b1;
    @(posedge clk); #1; regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] s, output logic [31:0] d, output logic irq);
    @(negedge clk); regSel = s; regRd = 1'b1; #1;
    d = regRdata; irq = irqOut;
    @(posedge clk); #1; regRd = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input int div);
    logic [9:0] frame;
    frame = {1'b1, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); rxDrv = frame[k];
      repeat (div - 1) @(negedge clk);
    end
  endtask

  task automatic waitLow(output bit ok);
    ok = 0;
    for (int n = 0; n < 5000 && !ok; n++) begin
      @(negedge clk);
      if (txOut == 1'b0) ok = 1;
    end
  endtask

  task automatic grabTx(input int div, output logic [7:0] b, output logic stopBit);
    bit ok;
    waitLow(ok);
    repeat (div / 2) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      repeat (div) @(negedge clk);
      b[k] = txOut;
    end
    repeat (div) @(negedge clk);
    stopBit = txOut;
  endtask

  task automatic measureGap(output int gap);
    bit ok;
    gap = 0;
    waitLow(ok);
    while (txOut == 1'b0 && gap < 5000) begin @(negedge clk); gap++; end
    while (txOut == 1'b1 && gap < 5000) begin @(negedge clk); gap++; end
  endtask

  // vector: sel[68:66] wr[65] data[64:33] expected[32:1] expIrq[0]
  localparam int NV = 15;
  localparam logic [68:0] VEC [NV] = '{
    {3'd6, 1'b0, 32'd0,          32'd4340,       1'b0},  // R1 divisor reset
    {3'd2, 1'b0, 32'd0,          32'd0,          1'b0},  // R1 tx control reset
    {3'd5, 1'b0, 32'd0,          32'd0,          1'b0},  // R1 R9 pending reset
    {3'd1, 1'b0, 32'd0,          32'h8000_0000,  1'b0},  // R3 empty read
    {3'd0, 1'b0, 32'd0,          32'd0,          1'b0},  // R2 not full
    {3'd2, 1'b1, 32'h0003_0000,  32'd0,          1'b0},
    {3'd5, 1'b0, 32'd0,          32'd1,          1'b0},  // R9 count 0 < wm 3
    {3'd4, 1'b1, 32'd1,          32'd0,          1'b0},
    {3'd4, 1'b0, 32'd0,          32'd1,          1'b1},  // R11 tx source
    {3'd5, 1'b1, 32'd0,          32'd0,          1'b0},
    {3'd5, 1'b0, 32'd0,          32'd1,          1'b1},  // R10 write ignored
    {3'd4, 1'b1, 32'd2,          32'd0,          1'b0},
    {3'd5, 1'b0, 32'd0,          32'd1,          1'b0},  // R11 masked
    {3'd6, 1'b1, 32'd4,          32'd0,          1'b0},
    {3'd6, 1'b0, 32'd0,          32'd4,          1'b0}   // R12 readback
  };

  initial begin
    logic [31:0] d;
    logic irq, stopBit;
    logic [7:0] b;
    logic [7:0] got [8];
    int n, gap;
    logic [68:0] v;

    repeat (4) @(negedge clk);
    chk("R1 txOut idle", {31'd0, txOut}, 32'd1);
    chk("R1 irq low", {31'd0, irqOut}, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      if (v[65]) wrReg(v[68:66], v[64:33]);
      else begin
        rdReg(v[68:66], d, irq);
        chk($sformatf("R1/R2/R3/R9-R12 vector %0d data", i), d, v[32:1]);
        chk($sformatf("R11 vector %0d irq", i), {31'd0, irq}, {31'd0, v[0]});
      end
    end

    // R2: fill transmit queue while transmitter disabled
    for (int i = 0; i < 8; i++) wrReg(3'd0, 32'h0000_0110 + i);
    rdReg(3'd0, d, irq);
    chk("R2 full flag", d, 32'h8000_0000);
    wrReg(3'd0, 32'h99);
    rdReg(3'd5, d, irq);
    chk("R9 count 8 not below wm 3", d, 32'd0);
    repeat (20) @(negedge clk);
    chk("R4 disabled line high", {31'd0, txOut}, 32'd1);

    // loopback: receive pushes can meet polling pops in one cycle
    loop = 1'b1;
    wrReg(3'd3, 32'h1);
    wrReg(3'd2, 32'h1);
    n = 0;
    for (int t = 0; t < 3000 && n < 8; t++) begin
      rdReg(3'd1, d, irq);
      if (!d[31]) begin got[n] = d[7:0]; n++; end
    end
    chk("R3 R5 R6 loopback byte count", n, 8);
    for (int i = 0; i < 8; i++)
      chk($sformatf("R3 R5 loopback byte %0d", i), {24'd0, got[i]}, 32'h10 + i);
    repeat (200) @(negedge clk);
    rdReg(3'd1, d, irq);
    chk("R2 write to full queue dropped", d, 32'h8000_0000);
    loop = 1'b0;

    // R5: frame shape at divisor 8
    wrReg(3'd6, 32'd8);
    wrReg(3'd0, 32'hA5);
    grabTx(8, b, stopBit);
    chk("R5 data LSB first", {24'd0, b}, 32'hA5);
    chk("R5 stop bit high", {31'd0, stopBit}, 32'd1);
    repeat (100) @(negedge clk);

    // R5: back-to-back spacing with one and two stop bits
    wrReg(3'd2, 32'h0);
    wrReg(3'd0, 32'hFF); wrReg(3'd0, 32'hFF);
    wrReg(3'd2, 32'h1);
    measureGap(gap);
    chk("R5 spacing one stop", gap, 80);
    repeat (200) @(negedge clk);
    wrReg(3'd2, 32'h0);
    wrReg(3'd0, 32'hFF); wrReg(3'd0, 32'hFF);
    wrReg(3'd2, 32'h3);
    measureGap(gap);
    chk("R5 spacing two stop", gap, 88);
    repeat (200) @(negedge clk);
    wrReg(3'd2, 32'h0);

    // R8: receive watermark 2, receive interrupt enabled (ie=2)
    wrReg(3'd3, 32'h0002_0001);
    sendByte(8'h3C, 8); sendByte(8'hC3, 8);
    rdReg(3'd5, d, irq);
    chk("R8 count 2 not above wm 2", d, 32'd0);
    sendByte(8'h5A, 8);
    repeat (4) @(negedge clk);
    rdReg(3'd5, d, irq);
    chk("R8 count 3 above wm 2", d, 32'd2);
    chk("R11 rx irq", {31'd0, irq}, 32'd1);
    rdReg(3'd1, d, irq);
    chk("R3 R6 oldest byte", d, 32'h3C);
    rdReg(3'd5, d, irq);
    chk("R8 self clear", d, 32'd0);
    rdReg(3'd1, d, irq); chk("R3 second byte", d, 32'hC3);
    rdReg(3'd1, d, irq); chk("R3 third byte", d, 32'h5A);
    rdReg(3'd1, d, irq); chk("R3 empty after drain", d, 32'h8000_0000);

    // R7: overflow of the receive queue
    wrReg(3'd3, 32'h1);
    for (int i = 0; i < 9; i++) sendByte(8'h40 + 8'(i), 8);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rdReg(3'd1, d, irq);
      chk($sformatf("R7 kept byte %0d", i), d, 32'h40 + i);
    end
    rdReg(3'd1, d, irq);
    chk("R7 ninth byte dropped", d, 32'h8000_0000);

    // R6: receiver disabled discards frames
    wrReg(3'd3, 32'h0);
    sendByte(8'h77, 8);
    wrReg(3'd3, 32'h1);
    repeat (10) @(negedge clk);
    rdReg(3'd1, d, irq);
    chk("R6 disabled frame discarded", d, 32'h8000_0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule